// File: doc/BRIEF.md
# Embedded-Sync 4:2:2 Video Line and Frame Formatter

This block turns a paced stream of 4:2:2 component samples into a complete interlaced frame of 525 lines with in-band synchronisation. It counts word slots and lines internally, places the four-word end-of-active and start-of-active timing codes, computes their protected status byte, and fills horizontal and vertical blanking with the black-level chroma/luma pair. It also drives a line-active strobe (HREF) and a frame-active level (VREF) for receivers that want separate sync.

The source offers one sample word at a time with a valid flag. The formatter pulls a word only when it asserts ready, which it does only in the video slots of active lines. A missing word at such a slot is replaced by the blanking value and flagged. An input selects a 10-bit interleaved stream on channel A, with one word per clock, or a 20-bit parallel stream with luma on channel A and chroma on channel B, updated every second clock. The default line has 1560 word slots, 1280 of them video, for a 640-pixel picture. The line length and video length are parameters.

Top module: `vid656_formatter`

## Requirements
- R1: Slots 0 to ACTIVE_WORDS-1 of each line are video slots. The end-of-active code takes slots ACTIVE_WORDS to ACTIVE_WORDS+3 and the start-of-active code takes the last four slots. Each code is the words 3FCh, 000h, 000h, then the status word, written in 10-bit form (8-bit value in bits 9:2, bits 1:0 zero).
- R2: The status byte is {1, F, V, H, V^H, F^H, F^V, F^V^H}. H is 1 in the end code and 0 in the start code. For FVH = 000..111 this gives 80h, 9Dh, ABh, B6h, C7h, DAh, ECh, F1h. Both codes of a line use that line's F and V.
- R3: Lines are numbered 1 to 525. V is 1 on lines 1–19 and 264–282 and 0 elsewhere. F is 0 on lines 4–265 and 1 on all other lines.
- R4: Blanking slots between the codes, and all video slots of lines with V=1, carry 200h on even slots and 040h on odd slots.
- R5: o_pix_ready is high exactly in the video slots of lines with V=0. A word that is accepted there (ready and valid) appears unchanged at the output, in arrival order (Cb, Y, Cr, Y, ...). The output follows its slot by one clock.
- R6: An accepted word below 004h is output as 004h, and one above 3FBh is output as 3FBh. The 8 MSBs of a video word are therefore never 00h or FFh.
- R7: If ready is high and valid is low, the slot carries its R4 blanking value and o_underrun is high for the one output cycle that carries that slot. Valid low while ready is low has no effect.
- R8: With i_par_mode=0, o_cha carries every slot, o_chb is zero and o_strobe is high on every clock.
- R9: With i_par_mode=1, outputs update only after odd slots. o_chb then carries the preceding even slot, o_cha carries the odd slot, and o_strobe is high only on those updates.
- R10: o_href is high only while the output carries video slots of a V=0 line. o_vref equals the inverse of V of the line being output.
- R11: In reset all outputs are zero. The first slot after reset is line 1, slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock (twice the luma rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_par_mode | input | 1 | 0 = 10-bit interleaved, 1 = 20-bit parallel |
| i_pix | input | 10 | Incoming sample word |
| i_pix_valid | input | 1 | Sample word present |
| o_pix_ready | output | 1 | Formatter takes a word this cycle |
| o_cha | output | 10 | Channel A (all words or luma) |
| o_chb | output | 10 | Channel B (zero or chroma) |
| o_strobe | output | 1 | New output data this cycle |
| o_href | output | 1 | Active-pixel indicator |
| o_vref | output | 1 | Active-line indicator |
| o_underrun | output | 1 | Missing sample was replaced |

## Verification
The bench targets the line boundaries where F and V change (lines 3/4, 19/20, 263/264, 265/266, 282/283 and the wrap from 525 to 1). A design with one off-by-one line compare would emit a wrong status byte there. It checks the first and last word of each code and of the fill, because a slot window shifted by one would place FFh inside video or leave a fill word in a code. The clamp is tested at both extremes, where a missing bound would let a video word mimic a code preamble. An underrun is forced inside video and valid is dropped inside blanking, which exposes a design that flags idle cycles or passes stale data. In parallel mode the bench checks the channel pairing and the hold cycles, which catches swapped channels or a strobe on every clock.

// File: rtl/vid656_pkg.sv
package vid656_pkg;
  localparam int WORD_W = 10;

  typedef enum logic [1:0] {
    SLOT_VIDEO = 2'd0,
    SLOT_END   = 2'd1,
    SLOT_FILL  = 2'd2,
    SLOT_START = 2'd3
  } slot_kind_e;

  localparam logic [7:0] FILL_CHROMA = 8'h80;
  localparam logic [7:0] FILL_LUMA   = 8'h10;
  localparam logic [WORD_W-1:0] CLAMP_LO = 10'h004;
  localparam logic [WORD_W-1:0] CLAMP_HI = 10'h3FB;

  // Status byte of a timing code: fixed one, flags, then the Hamming-style nibble
  function automatic logic [7:0] status_byte(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction
endpackage

// File: rtl/vid656_timing.sv
module vid656_timing
  import vid656_pkg::*;
#(
  parameter int LINE_WORDS   = 1560,
  parameter int ACTIVE_WORDS = 1280,
  parameter int FRAME_LINES  = 525,
  parameter int VB1_LAST     = 19,
  parameter int VB2_FIRST    = 264,
  parameter int VB2_LAST     = 282,
  parameter int F0_FIRST     = 4,
  parameter int F0_LAST      = 265
) (
  input  logic       clk,
  input  logic       rst_n,
  output slot_kind_e kind,
  output logic [1:0] code_idx,
  output logic       odd_slot,
  output logic       f_bit,
  output logic       v_bit
);
  localparam int HW  = $clog2(LINE_WORDS);
  localparam int LNW = $clog2(FRAME_LINES + 1);

  logic [HW-1:0]  hpos_q, hpos_n, offs;
  logic [LNW-1:0] line_q, line_n;
  logic           eol;

  always_comb begin
    eol    = (hpos_q == HW'(LINE_WORDS - 1));
    hpos_n = eol ? '0 : hpos_q + 1'b1;
    line_n = (line_q == LNW'(FRAME_LINES)) ? LNW'(1) : line_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hpos_q <= '0;
      line_q <= LNW'(1);
    end else begin
      hpos_q <= hpos_n;
      if (eol) line_q <= line_n;
    end
  end

  always_comb begin
    offs = '0;
    if (hpos_q < HW'(ACTIVE_WORDS)) begin
      kind = SLOT_VIDEO;
    end else if (hpos_q < HW'(ACTIVE_WORDS + 4)) begin
      kind = SLOT_END;
      offs = hpos_q - HW'(ACTIVE_WORDS);
    end else if (hpos_q >= HW'(LINE_WORDS - 4)) begin
      kind = SLOT_START;
      offs = hpos_q - HW'(LINE_WORDS - 4);
    end else begin
      kind = SLOT_FILL;
    end
    code_idx = offs[1:0];
    odd_slot = hpos_q[0];
    v_bit = (line_q <= LNW'(VB1_LAST)) ||
            ((line_q >= LNW'(VB2_FIRST)) && (line_q <= LNW'(VB2_LAST)));
    f_bit = !((line_q >= LNW'(F0_FIRST)) && (line_q <= LNW'(F0_LAST)));
  end
endmodule

// File: rtl/vid656_wordgen.sv
module vid656_wordgen
  import vid656_pkg::*;
(
  input  slot_kind_e        kind,
  input  logic [1:0]        code_idx,
  input  logic              odd_slot,
  input  logic              f_bit,
  input  logic              v_bit,
  input  logic [WORD_W-1:0] pix,
  input  logic              pix_valid,
  output logic              ready,
  output logic [WORD_W-1:0] word,
  output logic              href_w,
  output logic              underrun_w
);
  logic [7:0]        fill_b;
  logic [WORD_W-1:0] clamped;

  always_comb begin
    fill_b     = odd_slot ? FILL_LUMA : FILL_CHROMA;
    ready      = (kind == SLOT_VIDEO) && !v_bit;
    href_w     = ready;
    underrun_w = ready && !pix_valid;
    if (pix < CLAMP_LO)      clamped = CLAMP_LO;
    else if (pix > CLAMP_HI) clamped = CLAMP_HI;
    else                     clamped = pix;

    unique case (kind)
      SLOT_VIDEO: word = (ready && pix_valid) ? clamped : {fill_b, 2'b00};
      SLOT_FILL:  word = {fill_b, 2'b00};
      default: begin
        unique case (code_idx)
          2'd0:    word = {8'hFF, 2'b00};
          2'd3:    word = {status_byte(f_bit, v_bit, kind == SLOT_END), 2'b00};
          default: word = '0;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/vid656_outstage.sv
module vid656_outstage
  import vid656_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_mode,
  input  logic              odd_slot,
  input  logic [WORD_W-1:0] word,
  input  logic              href_w,
  input  logic              vref_w,
  input  logic              underrun_w,
  output logic [WORD_W-1:0] cha,
  output logic [WORD_W-1:0] chb,
  output logic              strobe,
  output logic              href,
  output logic              vref,
  output logic              underrun
);
  logic [WORD_W-1:0] hold_q, cha_q, chb_q, cha_n, chb_n;
  logic              href_q, vref_q, strobe_q, unr_q;
  logic              out_en, hold_en;

  always_comb begin
    out_en  = !par_mode || odd_slot;
    hold_en = par_mode && !odd_slot;
    cha_n   = word;
    chb_n   = par_mode ? hold_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      cha_q    <= '0;
      chb_q    <= '0;
      href_q   <= 1'b0;
      vref_q   <= 1'b0;
      strobe_q <= 1'b0;
      unr_q    <= 1'b0;
    end else begin
      strobe_q <= out_en;
      unr_q    <= underrun_w;
      if (hold_en) hold_q <= word;
      if (out_en) begin
        cha_q  <= cha_n;
        chb_q  <= chb_n;
        href_q <= href_w;
        vref_q <= vref_w;
      end
    end
  end

  assign cha      = cha_q;
  assign chb      = chb_q;
  assign strobe   = strobe_q;
  assign href     = href_q;
  assign vref     = vref_q;
  assign underrun = unr_q;
endmodule

// File: rtl/vid656_formatter.sv
module vid656_formatter
  import vid656_pkg::*;
#(
  parameter int LINE_WORDS   = 1560,
  parameter int ACTIVE_WORDS = 1280,
  parameter int FRAME_LINES  = 525,
  parameter int VB1_LAST     = 19,
  parameter int VB2_FIRST    = 264,
  parameter int VB2_LAST     = 282,
  parameter int F0_FIRST     = 4,
  parameter int F0_LAST      = 265
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_par_mode,
  input  logic [WORD_W-1:0] i_pix,
  input  logic              i_pix_valid,
  output logic              o_pix_ready,
  output logic [WORD_W-1:0] o_cha,
  output logic [WORD_W-1:0] o_chb,
  output logic              o_strobe,
  output logic              o_href,
  output logic              o_vref,
  output logic              o_underrun
);
  slot_kind_e        kind;
  logic [1:0]        code_idx;
  logic              odd_slot, f_bit, v_bit;
  logic [WORD_W-1:0] word;
  logic              href_w, underrun_w;

  vid656_timing #(
    .LINE_WORDS(LINE_WORDS), .ACTIVE_WORDS(ACTIVE_WORDS), .FRAME_LINES(FRAME_LINES),
    .VB1_LAST(VB1_LAST), .VB2_FIRST(VB2_FIRST), .VB2_LAST(VB2_LAST),
    .F0_FIRST(F0_FIRST), .F0_LAST(F0_LAST)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .kind(kind), .code_idx(code_idx),
    .odd_slot(odd_slot), .f_bit(f_bit), .v_bit(v_bit)
  );

  vid656_wordgen u_wordgen (
    .kind(kind), .code_idx(code_idx), .odd_slot(odd_slot), .f_bit(f_bit),
    .v_bit(v_bit), .pix(i_pix), .pix_valid(i_pix_valid), .ready(o_pix_ready),
    .word(word), .href_w(href_w), .underrun_w(underrun_w)
  );

  vid656_outstage u_out (
    .clk(clk), .rst_n(rst_n), .par_mode(i_par_mode), .odd_slot(odd_slot),
    .word(word), .href_w(href_w), .vref_w(!v_bit), .underrun_w(underrun_w),
    .cha(o_cha), .chb(o_chb), .strobe(o_strobe), .href(o_href),
    .vref(o_vref), .underrun(o_underrun)
  );
endmodule

// File: rtl/vid656_formatter_chk.sv
module vid656_formatter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       i_par_mode,
  input logic       i_pix_valid,
  input logic       o_pix_ready,
  input logic [9:0] o_cha,
  input logic [9:0] o_chb,
  input logic       o_strobe,
  input logic       o_href,
  input logic       o_vref,
  input logic       o_underrun
);
  logic started;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  AST_IL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    started && $past(!i_par_mode) |-> o_strobe) else $error("interleaved strobe gap"); // R8
  AST_IL_CHB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    started && $past(!i_par_mode) |-> o_chb == 10'h000) else $error("chb not idle"); // R8
  AST_HREF_IN_VREF: assert property (@(posedge clk) disable iff (!rst_n)
    o_href |-> o_vref) else $error("href outside active line"); // R10
  AST_VIDEO_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    o_href |-> (o_cha[9:2] != 8'h00) && (o_cha[9:2] != 8'hFF)) else $error("code value in video"); // R6
  AST_UNDERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    started && o_underrun |-> $past(o_pix_ready && !i_pix_valid)) else $error("spurious underrun"); // R7
  AST_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
    started && $past(!i_par_mode) && (o_cha == 10'h3FC) |=> ($past(i_par_mode) || o_cha == 10'h000))
    else $error("preamble broken"); // R1
endmodule

bind vid656_formatter vid656_formatter_chk u_chk (.*);

// File: tb/vid656_formatter_bench.sv
module vid656_formatter_bench;
  localparam int LW = 40;
  localparam int AW = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       i_par_mode = 1'b0;
  logic [9:0] i_pix = 10'h2A8;
  logic       i_pix_valid = 1'b1;
  logic       o_pix_ready, o_strobe, o_href, o_vref, o_underrun;
  logic [9:0] o_cha, o_chb;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  vid656_formatter #(.LINE_WORDS(LW), .ACTIVE_WORDS(AW)) u_vid656_formatter (
    .clk(clk), .rst_n(rst_n), .i_par_mode(i_par_mode), .i_pix(i_pix),
    .i_pix_valid(i_pix_valid), .o_pix_ready(o_pix_ready), .o_cha(o_cha),
    .o_chb(o_chb), .o_strobe(o_strobe), .o_href(o_href), .o_vref(o_vref),
    .o_underrun(o_underrun)
  );

  // {slot index from reset, expected o_cha, expected href, expected vref}
  localparam int NT = 24;
  localparam logic [43:0] TBL [NT] = '{
    {32'd0,     10'h200, 1'b0, 1'b0},  // line 1 vblank chroma fill
    {32'd1,     10'h040, 1'b0, 1'b0},
    {32'd16,    10'h3FC, 1'b0, 1'b0},  // end code preamble
    {32'd17,    10'h000, 1'b0, 1'b0},
    {32'd19,    10'h3C4, 1'b0, 1'b0},  // F1 V1 H1 -> F1h
    {32'd20,    10'h200, 1'b0, 1'b0},
    {32'd39,    10'h3B0, 1'b0, 1'b0},  // F1 V1 H0 -> ECh
    {32'd99,    10'h3C4, 1'b0, 1'b0},  // line 3
    {32'd139,   10'h2D8, 1'b0, 1'b0},  // line 4: F0 V1 H1 -> B6h
    {32'd760,   10'h2A8, 1'b1, 1'b1},  // line 20 video
    {32'd761,   10'h2A8, 1'b1, 1'b1},
    {32'd776,   10'h3FC, 1'b0, 1'b1},
    {32'd779,   10'h274, 1'b0, 1'b1},  // F0 V0 H1 -> 9Dh
    {32'd798,   10'h000, 1'b0, 1'b1},
    {32'd799,   10'h200, 1'b0, 1'b1},  // F0 V0 H0 -> 80h
    {32'd10499, 10'h274, 1'b0, 1'b1},  // line 263
    {32'd10520, 10'h200, 1'b0, 1'b0},  // line 264 vblank video slot
    {32'd10539, 10'h2D8, 1'b0, 1'b0},
    {32'd10619, 10'h3C4, 1'b0, 1'b0},  // line 266
    {32'd11282, 10'h2A8, 1'b1, 1'b1},  // line 283 video
    {32'd11299, 10'h368, 1'b0, 1'b1},  // F1 V0 H1 -> DAh
    {32'd11319, 10'h31C, 1'b0, 1'b1},  // F1 V0 H0 -> C7h
    {32'd20979, 10'h368, 1'b0, 1'b1},  // line 525
    {32'd21019, 10'h3C4, 1'b0, 1'b0}   // wrap to line 1
  };

  task automatic chk(input logic ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic wait_pos(input int p);
    @(negedge clk);
    while (cyc - 1 != p) @(negedge clk);
  endtask

  task automatic hold_pos(input int p);
    while (cyc - 1 != p) @(negedge clk);
  endtask

  initial begin
    #(8 * 60000);
    n_bad++;
    $display("FAIL watchdog act=%0d exp=done", cyc);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(o_cha == 0 && o_chb == 0, "R11 channels in reset", o_cha, 0);
    chk(!o_strobe && !o_href && !o_vref && !o_underrun && !o_pix_ready,
        "R11 flags in reset", {o_strobe, o_href, o_vref, o_underrun, o_pix_ready}, 0);
    rst_n = 1'b1;

    for (int k = 0; k < NT; k++) begin
      hold_pos(int'(TBL[k][43:12]));
      chk(o_cha == TBL[k][11:2], $sformatf("R1 R2 R3 R4 R5 word at %0d", TBL[k][43:12]),
          o_cha, TBL[k][11:2]);
      chk(o_href == TBL[k][1] && o_vref == TBL[k][0],
          $sformatf("R10 href/vref at %0d", TBL[k][43:12]), {o_href, o_vref}, TBL[k][1:0]);
      chk(o_strobe && o_chb == 0, "R8 interleaved strobe/chb", {o_strobe, o_chb}, 11'h400);
    end

    // R5: ready low in blanking (pos p shows ready for slot p+1)
    hold_pos(21020);
    chk(!o_pix_ready, "R5 ready in blanking", o_pix_ready, 0);
    i_pix_valid = 1'b0;
    // R7: valid low without ready has no effect
    wait_pos(21030);
    chk(!o_underrun && o_cha == 10'h200, "R7 idle valid ignored", {o_underrun, o_cha}, 10'h200);
    wait_pos(21040);
    i_pix_valid = 1'b1;
    wait_pos(21759);
    chk(o_pix_ready, "R5 ready at line start", o_pix_ready, 1);
    i_pix = 10'h000;
    wait_pos(21760);
    chk(o_cha == 10'h004, "R6 low clamp", o_cha, 10'h004);
    i_pix = 10'h3FF;
    wait_pos(21761);
    chk(o_cha == 10'h3FB, "R6 high clamp", o_cha, 10'h3FB);
    i_pix = 10'h123;
    wait_pos(21762);
    chk(o_cha == 10'h123, "R5 pass-through", o_cha, 10'h123);
    i_pix_valid = 1'b0;
    wait_pos(21763);
    chk(o_underrun && o_cha == 10'h040, "R7 underrun fill", {o_underrun, o_cha}, 11'h440);
    i_pix_valid = 1'b1;
    wait_pos(21764);
    chk(!o_underrun && o_cha == 10'h123, "R7 recovery", {o_underrun, o_cha}, 10'h123);

    // R9: parallel mode after a fresh reset
    rst_n = 1'b0;
    i_par_mode = 1'b1;
    i_pix = 10'h2A8;
    repeat (2) @(negedge clk);
    chk(o_cha == 0 && !o_strobe, "R11 second reset", {o_strobe, o_cha}, 0);
    rst_n = 1'b1;
    wait_pos(16);
    chk(!o_strobe, "R9 no strobe on even slot", o_strobe, 0);
    wait_pos(17);
    chk(o_strobe && o_chb == 10'h3FC && o_cha == 10'h000, "R9 code pair 1",
        {o_chb, o_cha}, {10'h3FC, 10'h000});
    wait_pos(19);
    chk(o_chb == 10'h000 && o_cha == 10'h3C4, "R9 code pair 2",
        {o_chb, o_cha}, {10'h000, 10'h3C4});
    wait_pos(21);
    chk(o_chb == 10'h200 && o_cha == 10'h040, "R9 fill pair", {o_chb, o_cha}, {10'h200, 10'h040});
    wait_pos(22);
    chk(!o_strobe && o_cha == 10'h040, "R9 hold between pairs", {o_strobe, o_cha}, 10'h040);
    wait_pos(759);
    i_pix = 10'h155;
    wait_pos(760);
    i_pix = 10'h2AA;
    wait_pos(761);
    chk(o_chb == 10'h155 && o_cha == 10'h2AA && o_href, "R9 R10 video pair",
        {o_href, o_chb, o_cha}, {1'b1, 10'h155, 10'h2AA});

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule